// File: doc/BRIEF.md
# Inband Loop Code Detector

This block watches one channel's received serial bit stream for the repeating in-band commands that ask a far end to close or open a line loopback. Every bit arrives with a valid strobe. A 2-bit mode input picks what the block looks for. It can be idle. It can look for the loop-up command, a period-5 pattern of four zeros then a one. It can look for the loop-down command, a period-3 pattern of two zeros then a one. In the automatic mode it also drives a remote loopback control.

A command counts only once it has been present without a break for longer than a persistence window. The window is a parameter, counted in valid received bits, so about five seconds at the line rate maps onto a plain bit count. A qualified command sets a sticky status bit. The interrupt output is that status gated by an enable input. In automatic mode, a qualified loop-up command also raises the loopback output. The block then watches for loop-down, and a qualified loop-down command drops the loopback again.

Top module: `loop_code_detector`

## Requirements
- R1: Mode is `mode[1:0]`: 00 = off, 01 = loop-up watch, 10 = loop-down watch, 11 = automatic. In mode 00 no pattern ever sets `status`, and `loopback` stays 0.
- R2: A received bit is in-pattern for loop-up when it and the UP_LEN-1 (4) valid bits before it hold exactly one 1.
- R3: A received bit is in-pattern for loop-down when it and the DOWN_LEN-1 (2) valid bits before it hold exactly one 1.
- R4: A detection happens on the valid bit that completes a run of HOLD_BITS+1 consecutive in-pattern bits, and `status` is 1 from the next clock edge on. Two things restart the run from zero: an out-of-pattern valid bit, or a change of `mode`.
- R5: Cycles with `rx_valid` low carry no bit. They neither extend nor break a run.
- R6: `status` is sticky. `stat_clr` clears it, and a detection in the same cycle wins over the clear. An uninterrupted run gives only one detection, so after a clear `status` stays 0 while the same run goes on.
- R7: `irq` is 1 exactly when `status` and `irq_en` are both 1.
- R8: Entering mode 11 clears `status` and `loopback`, and the block first watches for loop-up. While `loopback` is 0 in mode 11, the loop-down pattern has no effect.
- R9: In mode 11, a loop-up detection sets `status` and `loopback` together and switches the watch to loop-down. `status` and `loopback` stay 1 after the loop-up pattern stops.
- R10: `loopback` drops on a loop-down detection in mode 11, or when `mode` leaves 11. Neither event changes `status`.
- R11: Asserting `rst_n` low forces `status`, `irq` and `loopback` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received data bit |
| rx_valid | input | 1 | rx_bit carries a bit this cycle |
| mode | input | 2 | Detection mode (R1 encoding) |
| stat_clr | input | 1 | One-cycle pulse that clears status |
| irq_en | input | 1 | Interrupt enable |
| status | output | 1 | Sticky detection status |
| irq | output | 1 | Interrupt request |
| loopback | output | 1 | Remote loopback request |

## Verification
The assertions check these properties on every cycle:
- mode 00 never raises status;
- status holds unless cleared or the block enters mode 11;
- entering mode 11 clears both outputs;
- loopback rises only together with status and only in mode 11;
- an out-of-pattern bit empties the persistence count, an idle cycle leaves it unchanged, and the count never passes its limit.

Only the bench scenarios can show the rest:
- the exact bit on which a run qualifies for each pattern;
- that a run broken short of the window gives no detection;
- the sequence of automatic mode: loop-up detection, the switch to loop-down, and the release;
- that the clear sticks while the same run continues.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_UP   = 2'b01,
      MODE_DOWN = 2'b10,
      MODE_AUTO = 2'b11
   } lcd_mode_e;

   localparam int N_PATTERNS = 2;
   localparam int PAT_UP     = 0;
   localparam int PAT_DOWN   = 1;

endpackage

// File: rtl/lcd_pattern_window.sv
module lcd_pattern_window #(
   parameter int PERIOD = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   output logic hit
);

   localparam int HIST_W = PERIOD - 1;

   if (PERIOD < 2) begin : g_bad_period
      $error("lcd_pattern_window: PERIOD must be at least 2");
   end

   logic [HIST_W-1:0] hist_q;
   logic [PERIOD-1:0] window;

   // The newest bit sits in the LSB, and older bits shift up.
   assign window = {hist_q, bit_in};

   // Start from all ones so that reset state never looks like a pattern.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '1;
      end else if (bit_valid) begin
         hist_q <= window[HIST_W-1:0];
      end
   end

   // If every window of PERIOD bits holds exactly one 1, the stream
   // repeats with period PERIOD in the "zeros then a one" shape.
   always_comb begin
      hit = ($countones(window) == 1);
   end

endmodule

// File: rtl/lcd_persist_timer.sv
module lcd_persist_timer #(
   parameter int HOLD_BITS = 7_720_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic flush,
   input  logic rearm,
   input  logic bit_valid,
   input  logic hit,
   output logic fire
);

   localparam int          CNT_W = $clog2(HOLD_BITS + 2);
   localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(HOLD_BITS + 1);
   localparam logic [CNT_W-1:0] LIMIT_M1  = CNT_W'(HOLD_BITS);

   if (HOLD_BITS < 2) begin : g_bad_hold
      $error("lcd_persist_timer: HOLD_BITS must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             counting;

   assign counting = enable && !flush;

   // The run length saturates at LIMIT, so one run fires only once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!counting || rearm) begin
         cnt_q <= '0;
      end else if (bit_valid) begin
         if (!hit) begin
            cnt_q <= '0;
         end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      fire = counting && bit_valid && hit && (cnt_q == LIMIT_M1);
   end

   a_r4_miss_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && bit_valid && !hit) |=> (cnt_q == '0));

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (counting && !rearm && !bit_valid) |=> $stable(cnt_q));

   a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0));

endmodule

// File: rtl/lcd_loop_ctrl.sv
module lcd_loop_ctrl
   import lcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       stat_clr,
   input  logic       fire,
   output logic       det_enable,
   output logic       mode_flush,
   output logic       rearm,
   output logic       watch_down,
   output logic       status,
   output logic       loopback
);

   lcd_mode_e mode_cur;
   lcd_mode_e mode_q;
   logic      is_auto;
   logic      enter_auto;
   logic      status_q;
   logic      lb_q;

   assign mode_cur   = lcd_mode_e'(mode);
   assign is_auto    = (mode_cur == MODE_AUTO);
   assign mode_flush = (mode_cur != mode_q);
   assign enter_auto = mode_flush && is_auto;
   assign det_enable = (mode_cur != MODE_OFF);

   // In automatic mode each detection switches the target pattern.
   assign rearm      = fire && is_auto;
   assign watch_down = (mode_cur == MODE_DOWN) || (is_auto && lb_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_OFF;
         status_q <= 1'b0;
         lb_q     <= 1'b0;
      end else begin
         mode_q <= mode_cur;
         if (mode_flush) begin
            lb_q <= 1'b0;
            if (is_auto || stat_clr) begin
               status_q <= 1'b0;
            end
         end else if (fire) begin
            status_q <= 1'b1;
            if (is_auto) begin
               lb_q <= !lb_q;
            end
         end else if (stat_clr) begin
            status_q <= 1'b0;
         end
      end
   end

   assign status   = status_q;
   assign loopback = lb_q;

   a_r1_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cur == MODE_OFF) |=> !$rose(status_q));

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !stat_clr && !enter_auto) |=> status_q);

   a_r8_enter_clears: assert property (@(posedge clk) disable iff (!rst_n)
      enter_auto |=> (!status_q && !lb_q));

   a_r9_lb_with_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lb_q) |-> status_q);

   a_r10_lb_only_auto: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_AUTO) |-> !lb_q);

endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector
   import lcd_pkg::*;
#(
   parameter int HOLD_BITS = 7_720_000,
   parameter int UP_LEN    = 5,
   parameter int DOWN_LEN  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_bit,
   input  logic       rx_valid,
   input  logic [1:0] mode,
   input  logic       stat_clr,
   input  logic       irq_en,
   output logic       status,
   output logic       irq,
   output logic       loopback
);

   if (UP_LEN == DOWN_LEN) begin : g_bad_lens
      $error("loop_code_detector: the two pattern periods must differ");
   end

   logic [N_PATTERNS-1:0] pat_hit;
   logic                  sel_hit;
   logic                  fire;
   logic                  det_enable;
   logic                  mode_flush;
   logic                  rearm;
   logic                  watch_down;

   for (genvar g = 0; g < N_PATTERNS; g++) begin : g_match
      localparam int LEN = (g == PAT_UP) ? UP_LEN : DOWN_LEN;
      lcd_pattern_window #(.PERIOD(LEN)) u_win (
         .clk       (clk),
         .rst_n     (rst_n),
         .bit_valid (rx_valid),
         .bit_in    (rx_bit),
         .hit       (pat_hit[g])
      );
   end

   assign sel_hit = watch_down ? pat_hit[PAT_DOWN] : pat_hit[PAT_UP];

   lcd_persist_timer #(.HOLD_BITS(HOLD_BITS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (det_enable),
      .flush     (mode_flush),
      .rearm     (rearm),
      .bit_valid (rx_valid),
      .hit       (sel_hit),
      .fire      (fire)
   );

   lcd_loop_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .stat_clr   (stat_clr),
      .fire       (fire),
      .det_enable (det_enable),
      .mode_flush (mode_flush),
      .rearm      (rearm),
      .watch_down (watch_down),
      .status     (status),
      .loopback   (loopback)
   );

   assign irq = status & irq_en;

   a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

endmodule

// File: tb/loop_code_detector_test.sv
`timescale 1ns/1ps
module loop_code_detector_test;

   localparam int HOLD = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_bit = 1'b0;
   logic       rx_valid = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       stat_clr = 1'b0;
   logic       irq_en = 1'b0;
   logic       status;
   logic       irq;
   logic       loopback;

   int checks = 0;
   int fails = 0;
   int phase = 0;
   int last_kind = -1;
   bit done = 1'b0;

   always #2 clk = ~clk;

   loop_code_detector #(.HOLD_BITS(HOLD)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_bit   (rx_bit),
      .rx_valid (rx_valid),
      .mode     (mode),
      .stat_clr (stat_clr),
      .irq_en   (irq_en),
      .status   (status),
      .irq      (irq),
      .loopback (loopback)
   );

   // Row fields: mode[15:14] clr[13] irq_en[12] kind[11:10] nbits[9:2] st[1] lb[0]
   // kind: 0 = all ones, 1 = loop-up pattern, 2 = loop-down pattern
   localparam int NVEC = 26;
   localparam logic [15:0] VEC [NVEC] = '{
      {2'd1, 1'b0, 1'b1, 2'd0, 8'd8,  1'b0, 1'b0},  // R1 R2 idle ones
      {2'd1, 1'b0, 1'b1, 2'd1, 8'd23, 1'b0, 1'b0},  // R4 one bit short
      {2'd1, 1'b0, 1'b0, 2'd1, 8'd1,  1'b1, 1'b0},  // R2 R4 qualifies, R7 irq masked
      {2'd1, 1'b0, 1'b1, 2'd1, 8'd30, 1'b1, 1'b0},  // R6 R7 sticky
      {2'd1, 1'b1, 1'b1, 2'd1, 8'd10, 1'b0, 1'b0},  // R6 no refire in same run
      {2'd1, 1'b0, 1'b1, 2'd0, 8'd5,  1'b0, 1'b0},
      {2'd1, 1'b0, 1'b1, 2'd1, 8'd20, 1'b0, 1'b0},  // R4 partial run
      {2'd1, 1'b0, 1'b1, 2'd0, 8'd5,  1'b0, 1'b0},  // R4 break
      {2'd1, 1'b0, 1'b1, 2'd1, 8'd23, 1'b0, 1'b0},  // R4 run restarted
      {2'd1, 1'b0, 1'b1, 2'd1, 8'd1,  1'b1, 1'b0},
      {2'd2, 1'b1, 1'b1, 2'd0, 8'd5,  1'b0, 1'b0},
      {2'd2, 1'b0, 1'b1, 2'd2, 8'd21, 1'b0, 1'b0},  // R3 one short
      {2'd2, 1'b0, 1'b1, 2'd2, 8'd1,  1'b1, 1'b0},  // R3 qualifies
      {2'd2, 1'b1, 1'b1, 2'd1, 8'd40, 1'b0, 1'b0},  // R3 loop-up not loop-down
      {2'd0, 1'b0, 1'b1, 2'd1, 8'd40, 1'b0, 1'b0},  // R1 off
      {2'd3, 1'b0, 1'b1, 2'd0, 8'd5,  1'b0, 1'b0},
      {2'd3, 1'b0, 1'b1, 2'd1, 8'd24, 1'b1, 1'b1},  // R9 activate
      {2'd3, 1'b0, 1'b1, 2'd1, 8'd30, 1'b1, 1'b1},  // R9 holds
      {2'd3, 1'b0, 1'b1, 2'd0, 8'd5,  1'b1, 1'b1},  // R9 after loop-up stops
      {2'd3, 1'b0, 1'b1, 2'd2, 8'd21, 1'b1, 1'b1},  // R10 one short
      {2'd3, 1'b0, 1'b1, 2'd2, 8'd1,  1'b1, 1'b0},  // R10 released
      {2'd3, 1'b0, 1'b1, 2'd0, 8'd5,  1'b1, 1'b0},
      {2'd3, 1'b0, 1'b1, 2'd1, 8'd24, 1'b1, 1'b1},  // R9 again
      {2'd1, 1'b0, 1'b1, 2'd0, 8'd5,  1'b1, 1'b0},  // R10 leaving mode 11
      {2'd3, 1'b0, 1'b1, 2'd0, 8'd5,  1'b0, 1'b0},  // R8 entering clears
      {2'd3, 1'b0, 1'b1, 2'd2, 8'd40, 1'b0, 1'b0}   // R8 loop-down ignored
   };

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic st, input logic lb);
      check(req, "status", status, st);
      check(req, "loopback", loopback, lb);
      check("R7", "irq", irq, st & irq_en);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b0;
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      if (m !== mode) begin
         @(negedge clk);
         mode = m;
         rx_valid = 1'b0;
         idle(2);
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      rx_valid = 1'b0;
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
   endtask

   function automatic logic pat_bit(input int kind, input int p);
      if (kind == 1) return (p % 5) == 4;
      if (kind == 2) return (p % 3) == 2;
      return 1'b1;
   endfunction

   task automatic feed(input int kind, input int n, input int gap);
      if (kind != last_kind) phase = 0;
      last_kind = kind;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_bit = pat_bit(kind, phase);
         rx_valid = 1'b1;
         phase++;
         if (gap > 0) idle(gap);
      end
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      idle(3);
      check_all("R11", 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      check_all("R11", 1'b0, 1'b0);

      for (int r = 0; r < NVEC; r++) begin
         logic [15:0] v;
         v = VEC[r];
         set_mode(v[15:14]);
         irq_en = v[12];
         if (v[13]) pulse_clr();
         feed(int'(v[11:10]), int'(v[9:2]), 0);
         check_all($sformatf("row%0d", r), v[1], v[0]);
      end

      // R5: idle cycles between bits neither extend nor break a run
      set_mode(2'd1);
      pulse_clr();
      feed(0, 5, 0);
      feed(1, 23, 2);
      check_all("R5", 1'b0, 1'b0);
      feed(1, 1, 2);
      check_all("R5", 1'b1, 1'b0);

      // R4: a mode change restarts the run
      pulse_clr();
      feed(0, 5, 0);
      feed(1, 20, 0);
      set_mode(2'd2);
      set_mode(2'd1);
      feed(1, 20, 0);
      check_all("R4", 1'b0, 1'b0);
      feed(1, 1, 0);
      check_all("R4", 1'b1, 1'b0);

      // R11: reset during active loopback
      set_mode(2'd3);
      feed(0, 5, 0);
      feed(1, 24, 0);
      check_all("R9", 1'b1, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_all("R11", 1'b0, 1'b0);
      idle(2);
      rst_n = 1'b1;
      idle(2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule